// File: doc/BRIEF.md
# Coalesced-Interrupt EOI Tracker

This block follows the end-of-interrupt acknowledgements for one special edge-triggered timer interrupt. The source of that interrupt needs to know whether a new edge was really injected or was merged into a previous one that some CPU is still servicing. The tracker keeps two things: a bitmap with one bit per destination CPU that accepted the last delivery, and a counter of acknowledgements still owed.

The pin logic reads the `coalesced` flag before it accepts a new edge. When it delivers, it reports the accepting destinations and their number. Each acknowledgement arrives tagged with a destination index. Three restore operations keep the state consistent:

- A full resync clears everything.
- A per-destination fix-up sets or clears a single bit from a "still pending" input.
- An automatic rebuild from the per-destination pending vector runs when the counter would otherwise underflow or overflow. The rebuild is reported through a one-cycle error strobe.

All state is registered. Results of the inputs applied in one cycle appear on the outputs after the next rising clock edge.

Top module: `ctrk_top`

## Requirements
- R1: `coalesced` is high exactly when `outstanding` is non-zero.
- R2: A delivery report (`dlv_valid`) that arrives while `outstanding` is non-zero is ignored. The bitmap and the counter keep their values.
- R3: A delivery report that arrives while `outstanding` is zero loads the bitmap with `dlv_mask` and the counter with `dlv_count`. If `dlv_fail` is 1, it loads zero into both instead.
- R4: An acknowledgement (`eoi_valid`, index `eoi_dest`) whose destination bit is set clears that bit and lowers `outstanding` by one.
- R5: An acknowledgement whose destination bit is clear leaves the bitmap and `outstanding` unchanged.
- R6: If an update would take the counter below zero or above N, `err_pulse` is high for that one cycle. The bitmap is then reloaded from `pend_vec`, and `outstanding` becomes the number of ones in `pend_vec`.
- R7: `resync` zeroes the counter and clears the whole bitmap, so that later acknowledgements have no effect. It takes priority over all other inputs in that cycle.
- R8: A fix-up (`fix_valid`, index `fix_dest`, value `fix_pending`) writes one bit. It adds one to the counter when the bit goes from 0 to 1 and subtracts one when it goes from 1 to 0. Otherwise the counter is left alone.
- R9: When a delivery report and an acknowledgement arrive in the same cycle, the delivery is applied first and the acknowledgement is applied to its result. A fix-up in that same cycle is applied last.
- R10: Synchronous active-high `rst` gives `outstanding` = 0, `coalesced` = 0 and `err_pulse` = 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery report strobe |
| dlv_fail | input | 1 | Delivery failed; counter and bitmap load zero |
| dlv_mask | input | N | Destinations that accepted the delivery |
| dlv_count | input | CW | Number of destinations that accepted |
| eoi_valid | input | 1 | Acknowledgement strobe |
| eoi_dest | input | IW | Acknowledging destination index |
| fix_valid | input | 1 | Per-destination fix-up strobe |
| fix_dest | input | IW | Fix-up destination index |
| fix_pending | input | 1 | New value of that destination's bit |
| resync | input | 1 | Clear the counter and the bitmap |
| pend_vec | input | N | Per-destination pending state used for rebuild |
| coalesced | output | 1 | New edge would be merged |
| outstanding | output | CW | Acknowledgements still owed |
| err_pulse | output | 1 | One-cycle underflow or overflow strobe |

## Verification
Directed cases are used to separate behaviours that random traffic would blur together:

- A delivery arriving while the tracker is busy, distinguished from one arriving while it is idle.
- Acknowledgements from destinations whose bit is set, compared with acknowledgements from destinations whose bit is clear.
- A delivery and an acknowledgement in the same cycle, which shows whether the two are applied in the required order.
- A delivery count that does not match its mask, which forces an underflow and a rebuild from `pend_vec`.

Seeded random traffic then mixes all inputs, with mismatched counts and fix-ups included. This exercises chains where a rebuild is followed in the same cycle by a fix-up, and every cycle is compared with a reference model in the bench.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;

    typedef enum logic [1:0] {
        STEP_KEEP  = 2'd0,
        STEP_INC   = 2'd1,
        STEP_DEC   = 2'd2,
        STEP_FAULT = 2'd3
    } step_e;

    // Number of ones in a vector (up to 64 destinations).
    function automatic int unsigned ones64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // Decide how one bit update moves the counter.
    function automatic step_e step_decide(input logic en, input logic cur,
                                          input logic want, input logic at_zero,
                                          input logic at_full);
        if (!en || (cur == want)) begin
            return STEP_KEEP;
        end
        if (want) begin
            return at_full ? STEP_FAULT : STEP_INC;
        end
        return at_zero ? STEP_FAULT : STEP_DEC;
    endfunction

endpackage

// File: rtl/ctrk_load.sv
module ctrk_load
    import ctrk_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  map_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          dlv_valid,
    input  logic          dlv_fail,
    input  logic [N-1:0]  dlv_mask,
    input  logic [CW-1:0] dlv_count,
    output logic [N-1:0]  map_o,
    output logic [CW-1:0] cnt_o
);
    logic take;

    assign take = dlv_valid && (cnt_i == '0);

    always_comb begin
        map_o = map_i;
        cnt_o = cnt_i;
        if (take) begin
            if (dlv_fail) begin
                map_o = '0;
                cnt_o = '0;
            end else begin
                map_o = dlv_mask;
                cnt_o = dlv_count;
            end
        end
    end
endmodule

// File: rtl/ctrk_step.sv
module ctrk_step
    import ctrk_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]  map_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          en,
    input  logic [IW-1:0] idx,
    input  logic          want,
    input  logic [N-1:0]  pend,
    output logic [N-1:0]  map_o,
    output logic [CW-1:0] cnt_o,
    output logic          fault_o
);
    logic  in_range;
    logic  cur;
    step_e step;

    assign in_range = (32'(idx) < N);
    assign cur      = in_range ? map_i[idx] : 1'b0;

    always_comb begin
        step    = step_decide(en && in_range, cur, want, cnt_i == '0,
                              32'(cnt_i) >= N);
        map_o   = map_i;
        cnt_o   = cnt_i;
        fault_o = 1'b0;
        case (step)
            STEP_INC: begin
                map_o[idx] = 1'b1;
                cnt_o      = cnt_i + CW'(1);
            end
            STEP_DEC: begin
                map_o[idx] = 1'b0;
                cnt_o      = cnt_i - CW'(1);
            end
            STEP_FAULT: begin
                map_o   = pend;
                cnt_o   = CW'(ones64(64'(pend)));
                fault_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctrk_top.sv
module ctrk_top
    import ctrk_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1),
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dlv_valid,
    input  logic          dlv_fail,
    input  logic [N-1:0]  dlv_mask,
    input  logic [CW-1:0] dlv_count,
    input  logic          eoi_valid,
    input  logic [IW-1:0] eoi_dest,
    input  logic          fix_valid,
    input  logic [IW-1:0] fix_dest,
    input  logic          fix_pending,
    input  logic          resync,
    input  logic [N-1:0]  pend_vec,
    output logic          coalesced,
    output logic [CW-1:0] outstanding,
    output logic          err_pulse
);
    localparam int NSTAGE = 3;

    logic [N-1:0]  map_q;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    // Stage chain: delivery load, acknowledgement, fix-up.
    logic [N-1:0]  map_s [NSTAGE+1];
    logic [CW-1:0] cnt_s [NSTAGE+1];
    logic          flt_eoi;
    logic          flt_fix;

    assign map_s[0] = map_q;
    assign cnt_s[0] = cnt_q;

    ctrk_load #(.N(N), .CW(CW)) i_load (
        .map_i     (map_s[0]),
        .cnt_i     (cnt_s[0]),
        .dlv_valid (dlv_valid),
        .dlv_fail  (dlv_fail),
        .dlv_mask  (dlv_mask),
        .dlv_count (dlv_count),
        .map_o     (map_s[1]),
        .cnt_o     (cnt_s[1])
    );

    ctrk_step #(.N(N), .CW(CW), .IW(IW)) i_eoi (
        .map_i   (map_s[1]),
        .cnt_i   (cnt_s[1]),
        .en      (eoi_valid),
        .idx     (eoi_dest),
        .want    (1'b0),
        .pend    (pend_vec),
        .map_o   (map_s[2]),
        .cnt_o   (cnt_s[2]),
        .fault_o (flt_eoi)
    );

    ctrk_step #(.N(N), .CW(CW), .IW(IW)) i_fix (
        .map_i   (map_s[2]),
        .cnt_i   (cnt_s[2]),
        .en      (fix_valid),
        .idx     (fix_dest),
        .want    (fix_pending),
        .pend    (pend_vec),
        .map_o   (map_s[3]),
        .cnt_o   (cnt_s[3]),
        .fault_o (flt_fix)
    );

    always_ff @(posedge clk) begin
        if (rst || resync) begin
            map_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            map_q <= map_s[NSTAGE];
            cnt_q <= cnt_s[NSTAGE];
            err_q <= flt_eoi | flt_fix;
        end
    end

    assign coalesced   = (cnt_q != '0);
    assign outstanding = cnt_q;
    assign err_pulse   = err_q;
endmodule

// File: rtl/ctrk_chk.sv
module ctrk_chk #(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          dlv_valid,
    input logic          eoi_valid,
    input logic          fix_valid,
    input logic          resync,
    input logic          coalesced,
    input logic [CW-1:0] outstanding,
    input logic          err_pulse
);
    // R10: reset leaves everything idle
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (outstanding == '0) && !coalesced && !err_pulse);

    // R7: resync clears the counter without raising an error
    a_r7_resync_clears: assert property (@(posedge clk) disable iff (rst)
        resync |=> (outstanding == '0) && !err_pulse);

    // R2: a busy tracker ignores a lone delivery report
    a_r2_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (coalesced && dlv_valid && !eoi_valid && !fix_valid && !resync)
        |=> (outstanding == $past(outstanding)));

    // R4 / R5: a lone acknowledgement moves the counter down by at most one
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !dlv_valid && !fix_valid && !resync)
        |=> err_pulse || (outstanding == $past(outstanding))
            || (outstanding == $past(outstanding) - CW'(1)));

    // R6: without any command no error can appear
    a_r6_quiet_no_err: assert property (@(posedge clk) disable iff (rst)
        (!dlv_valid && !eoi_valid && !fix_valid)
        |=> !err_pulse && (outstanding == $past(outstanding)) || $past(resync));
endmodule

bind ctrk_top ctrk_chk #(.N(N), .CW(CW), .IW(IW)) i_ctrk_chk (
    .clk         (clk),
    .rst         (rst),
    .dlv_valid   (dlv_valid),
    .eoi_valid   (eoi_valid),
    .fix_valid   (fix_valid),
    .resync      (resync),
    .coalesced   (coalesced),
    .outstanding (outstanding),
    .err_pulse   (err_pulse)
);

// File: tb/test_ctrk_top.sv
`timescale 1ns/1ps
module test_ctrk_top;
    localparam int N  = 8;
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic          dlv_valid, dlv_fail;
    logic [N-1:0]  dlv_mask;
    logic [CW-1:0] dlv_count;
    logic          eoi_valid;
    logic [IW-1:0] eoi_dest;
    logic          fix_valid;
    logic [IW-1:0] fix_dest;
    logic          fix_pending;
    logic          resync;
    logic [N-1:0]  pend_vec;
    logic          coalesced;
    logic [CW-1:0] outstanding;
    logic          err_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [N-1:0] m_map;
    int           m_cnt;
    bit           m_err;

    always #5 clk = ~clk;

    ctrk_top #(.N(N)) i_ctrk_top (
        .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_fail(dlv_fail),
        .dlv_mask(dlv_mask), .dlv_count(dlv_count), .eoi_valid(eoi_valid),
        .eoi_dest(eoi_dest), .fix_valid(fix_valid), .fix_dest(fix_dest),
        .fix_pending(fix_pending), .resync(resync), .pend_vec(pend_vec),
        .coalesced(coalesced), .outstanding(outstanding), .err_pulse(err_pulse)
    );

    function automatic int popc(input logic [N-1:0] v);
        int n = 0;
        for (int i = 0; i < N; i++) n += int'(v[i]);
        return n;
    endfunction

    // Apply one bit update to the model; returns 1 on fault (R6).
    function automatic bit bit_update(input int d, input bit want);
        if (m_map[d] == want) return 0;
        if (want) begin
            if (m_cnt >= N) begin m_map = pend_vec; m_cnt = popc(pend_vec); return 1; end
            m_map[d] = 1'b1; m_cnt++;
        end else begin
            if (m_cnt == 0) begin m_map = pend_vec; m_cnt = popc(pend_vec); return 1; end
            m_map[d] = 1'b0; m_cnt--;
        end
        return 0;
    endfunction

    function automatic void model_clock();
        bit f;
        f = 0;
        if (rst || resync) begin
            m_map = '0; m_cnt = 0; m_err = 0;
            return;
        end
        if (dlv_valid && m_cnt == 0) begin           // R3 / R2 / R9 order
            m_map = dlv_fail ? '0 : dlv_mask;
            m_cnt = dlv_fail ? 0 : int'(dlv_count);
        end
        if (eoi_valid) f |= bit_update(int'(eoi_dest), 1'b0);     // R4 / R5
        if (fix_valid) f |= bit_update(int'(fix_dest), fix_pending); // R8
        m_err = f;
    endfunction

    task automatic check(input string tag);
        total++;
        if (int'(outstanding) != m_cnt || coalesced != (m_cnt != 0) || err_pulse != m_err) begin
            bad++;
            $display("FAIL %s: outstanding=%0d coalesced=%0b err=%0b expected %0d %0b %0b",
                     tag, outstanding, coalesced, err_pulse, m_cnt, m_cnt != 0, m_err);
        end
    endtask

    task automatic idle_inputs();
        rst = 0; dlv_valid = 0; dlv_fail = 0; dlv_mask = '0; dlv_count = '0;
        eoi_valid = 0; eoi_dest = '0; fix_valid = 0; fix_dest = '0;
        fix_pending = 0; resync = 0;
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check(tag);
        idle_inputs();
    endtask

    task automatic deliver(input logic [N-1:0] m, input int c, input bit fl);
        dlv_valid = 1; dlv_mask = m; dlv_count = CW'(c); dlv_fail = fl;
    endtask

    task automatic ack(input int d);
        eoi_valid = 1; eoi_dest = IW'(d);
    endtask

    task automatic fix(input int d, input bit p);
        fix_valid = 1; fix_dest = IW'(d); fix_pending = p;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        pend_vec = 8'h30;
        m_map = '0; m_cnt = 0; m_err = 0;
        @(negedge clk);
        rst = 1; cycle("R10 reset");
        cycle("R10 idle after reset");

        deliver(8'h05, 2, 0); cycle("R3 load, R1 flag high");
        deliver(8'hFF, 8, 0); cycle("R2 busy delivery ignored");
        ack(1); cycle("R5 ack from clear bit");
        ack(0); cycle("R4 ack decrements");
        ack(2); cycle("R1 flag low at zero");
        deliver(8'h0F, 4, 1); cycle("R3 failed delivery loads zero");
        deliver(8'h01, 1, 0); ack(0); cycle("R9 delivery then ack same cycle");
        deliver(8'h06, 1, 0); cycle("R3 mismatched count");
        ack(1); cycle("R4 ack to zero");
        ack(2); cycle("R6 underflow rebuild");
        cycle("R6 strobe lasts one cycle");
        fix(4, 1); cycle("R8 fix-up unchanged bit");
        fix(6, 1); cycle("R8 fix-up sets bit");
        fix(4, 0); cycle("R8 fix-up clears bit");
        resync = 1; ack(3); cycle("R7 resync clears");
        ack(5); cycle("R7 ack after resync no effect");

        for (int k = 0; k < 3000; k++) begin
            pend_vec = N'($urandom);
            if ($urandom_range(99) < 20) deliver(N'($urandom), $urandom_range(N), $urandom_range(9) == 0);
            if ($urandom_range(99) < 45) ack($urandom_range(N - 1));
            if ($urandom_range(99) < 15) fix($urandom_range(N - 1), $urandom_range(1));
            if ($urandom_range(99) < 3) resync = 1;
            if ($urandom_range(199) < 1) rst = 1;
            cycle("R1-mix random R2 R3 R4 R5 R6 R7 R8 R9");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule